// File: doc/BRIEF.md
# Synthesizer Divider Configuration Controller

This block holds the settings of a clock synthesizer: a 9-bit feedback divide value, a 2-bit output divide code and a 2-bit test selector. Two loading paths write the same registers. In the parallel path the divide values come from pins and follow them while an active-low load strobe is low; the rising edge of that strobe freezes them. In the serial path a 14-bit frame is shifted in on a slow serial clock and a separate load strobe moves it into the registers. While that strobe is held high, every shift also updates the registers.

All pins are sampled by a fast system clock. Each pin passes through a two-flop synchronizer, and the strobes are edge-detected after it. A test output picks one of four sources. Two small behavioural divider counters supply its clock-like inputs. A master reset input stops these counters without touching the stored settings.

Top module: `synth_div_cfg`

## Requirements
- R1: While `rst_n` is low, `mDiv`, `nCode` and `testSel` are 0, `testOut` is 0, `fOut` is 0 and `fOutN` is 1.
- R2: While the synchronized `parLoadN` is 0 (parallel mode), `mDiv` and `nCode` follow `mPins` and `nPins`, and `testOut` is 0.
- R3: On the rising edge of `parLoadN` the pin values are kept. Later pin changes have no effect until `parLoadN` falls again or a serial transfer (R5, R6) occurs.
- R4: While `parLoadN` is 1 and `serLoad` is 0, each rising edge of `serClk` shifts `serData` into a 14-bit register. The frame is sent first bit to last as: test select high bit, test select low bit, one unused slot, output-code high bit, output-code low bit, then divide value bit 8 down to bit 0. The unused slot never reaches any output, and shifting alone leaves the outputs unchanged.
- R5: A rising edge of `serLoad` copies the shift register into `testSel`, `nCode` and `mDiv`. After `serLoad` falls, further shifting leaves them unchanged.
- R6: While `serLoad` stays 1, each rising edge of `serClk` shifts and at once copies the new shift contents into `testSel`, `nCode` and `mDiv`.
- R7: In serial mode `testOut` is selected by `testSel`: 0 gives constant 0, 1 gives the synchronized `serData`, 2 gives the feedback divider pulse, 3 gives `fOut`.
- R8: `fOut` is bit `nCode` of a 4-bit counter that counts up on every system clock. Codes 0, 1, 2 and 3 therefore give periods of 2, 4, 8 and 16 clocks, each high for exactly half the period. `fOutN` is always the complement of `fOut`.
- R9: While the synchronized `masterRst` is 1, `fOut` is 0, `fOutN` is 1 and the divider pulse is 0. `mDiv`, `nCode` and `testSel` are unchanged.
- R10: The feedback divider pulse is high for one clock every `mDiv` clocks, or on every clock when `mDiv` is below 2.
- R11: A change on an input pin affects the registered settings at the third rising clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `serClk` |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| masterRst | input | 1 | Active-high divider reset; settings are kept |
| parLoadN | input | 1 | Active-low parallel load strobe and mode select |
| mPins | input | 9 | Parallel feedback divide value |
| nPins | input | 2 | Parallel output divide code |
| serClk | input | 1 | Serial shift clock, sampled |
| serData | input | 1 | Serial data |
| serLoad | input | 1 | Serial transfer strobe |
| mDiv | output | 9 | Current feedback divide value |
| nCode | output | 2 | Current output divide code |
| testSel | output | 2 | Current test select |
| testOut | output | 1 | Selected test signal |
| fOut | output | 1 | Divided output clock |
| fOutN | output | 1 | Complement of `fOut` |

## Verification
Parallel loads are applied with pin changes both before and after the strobe rises, which separates transparent behaviour from latched behaviour. Serial frames are sent with the unused slot set to 1 and `serLoad` pulsed only after shifting ends. Another frame is then shifted with `serLoad` kept high, which separates plain transfer from pass-through. A timed pin change measures the three-edge latency. Each test select value is tried, and rising edges and high cycles of `testOut` are counted over fixed windows for every output code and for one divide value, so that a wrong ratio or a wrong duty cycle shows up as a count error.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  // strobes from the control logic to the register datapath
  typedef struct packed {
    logic parMode;   // parallel mode: pins are transparent
    logic parLatch;  // rising edge of the parallel strobe
    logic serShift;  // rising serial clock in serial mode
    logic serXfer;   // rising serial load in serial mode
    logic serPass;   // serial clock while serial load stays high
  } cfgStrobe_t;
endpackage

// File: rtl/synth_cfg_sync.sv
module synth_cfg_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] syncOut,
  output logic [WIDTH-1:0] prevOut
);
  // STAGES flops form the synchronizer, one more holds the previous value
  logic [STAGES:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], rawIn};
  end

  assign syncOut = pipe[STAGES-1];
  assign prevOut = pipe[STAGES];
endmodule

// File: rtl/synth_cfg_strobe.sv
module synth_cfg_strobe
  import synth_cfg_pkg::*;
(
  input  logic       syncPl,
  input  logic       prevPl,
  input  logic       syncCk,
  input  logic       prevCk,
  input  logic       syncLd,
  input  logic       prevLd,
  output cfgStrobe_t strobe
);
  logic plRise, ckRise, ldRise, serMode;

  always_comb begin
    plRise  = syncPl & ~prevPl;
    ckRise  = syncCk & ~prevCk;
    ldRise  = syncLd & ~prevLd;
    serMode = syncPl & ~plRise;
    strobe.parMode  = ~syncPl;
    strobe.parLatch = plRise;
    strobe.serXfer  = serMode & ldRise;
    strobe.serShift = serMode & ckRise;
    strobe.serPass  = serMode & ckRise & syncLd & ~ldRise;
  end
endmodule

// File: rtl/synth_cfg_core.sv
module synth_cfg_core
  import synth_cfg_pkg::*;
#(
  parameter int M_WIDTH = 9,
  parameter int N_WIDTH = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  cfgStrobe_t                   strobe,
  input  logic                         mrSync,
  input  logic                         serDataSync,
  input  logic [M_WIDTH-1:0]           pinM,
  input  logic [N_WIDTH-1:0]           pinN,
  output logic [M_WIDTH-1:0]           mReg,
  output logic [N_WIDTH-1:0]           nReg,
  output logic [1:0]                   tReg,
  output logic [M_WIDTH+N_WIDTH+2:0]   shiftQ,
  output logic                         mPulse,
  output logic                         testOut,
  output logic                         fOut,
  output logic                         fOutN
);
  localparam int FRAME   = M_WIDTH + N_WIDTH + 3;
  localparam int OUT_CW  = 1 << N_WIDTH;

  logic [FRAME-1:0]   shiftNext, loadSrc;
  logic [OUT_CW-1:0]  outCnt;
  logic [M_WIDTH-1:0] mCnt;
  logic               mWrap;

  assign shiftNext = {shiftQ[FRAME-2:0], serDataSync};
  assign loadSrc   = strobe.serXfer ? shiftQ : shiftNext;

  // configuration and shift registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mReg   <= '0;
      nReg   <= '0;
      tReg   <= '0;
      shiftQ <= '0;
    end else if (strobe.parMode || strobe.parLatch) begin
      mReg <= pinM;
      nReg <= pinN;
    end else begin
      if (strobe.serShift) shiftQ <= shiftNext;
      if (strobe.serXfer || strobe.serPass) begin
        tReg <= loadSrc[FRAME-1:FRAME-2];
        nReg <= loadSrc[M_WIDTH+N_WIDTH-1:M_WIDTH];
        mReg <= loadSrc[M_WIDTH-1:0];
      end
    end
  end

  // behavioural divider counters feeding the test select
  assign mWrap = ({1'b0, mCnt} + 1'b1) >= {1'b0, mReg};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outCnt <= '0;
      mCnt   <= '0;
      mPulse <= 1'b0;
    end else if (mrSync) begin
      outCnt <= '0;
      mCnt   <= '0;
      mPulse <= 1'b0;
    end else begin
      outCnt <= outCnt + 1'b1;
      mCnt   <= mWrap ? '0 : mCnt + 1'b1;
      mPulse <= mWrap;
    end
  end

  assign fOut  = outCnt[nReg];
  assign fOutN = ~fOut;

  always_comb begin
    if (strobe.parMode) testOut = 1'b0;
    else begin
      unique case (tReg)
        2'd0:    testOut = 1'b0;
        2'd1:    testOut = serDataSync;
        2'd2:    testOut = mPulse;
        default: testOut = fOut;
      endcase
    end
  end
endmodule

// File: rtl/synth_div_cfg.sv
module synth_div_cfg
  import synth_cfg_pkg::*;
#(
  parameter int M_WIDTH     = 9,
  parameter int N_WIDTH     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               masterRst,
  input  logic               parLoadN,
  input  logic [M_WIDTH-1:0] mPins,
  input  logic [N_WIDTH-1:0] nPins,
  input  logic               serClk,
  input  logic               serData,
  input  logic               serLoad,
  output logic [M_WIDTH-1:0] mDiv,
  output logic [N_WIDTH-1:0] nCode,
  output logic [1:0]         testSel,
  output logic               testOut,
  output logic               fOut,
  output logic               fOutN
);
  localparam int RAW_W = M_WIDTH + N_WIDTH + 5;
  localparam int FRAME = M_WIDTH + N_WIDTH + 3;

  logic [RAW_W-1:0] rawVec, syncVec, prevVec;
  logic [FRAME-1:0] shiftQ;
  cfgStrobe_t       strobe;
  logic             mrSync, serDataSync, mPulse;

  assign rawVec = {masterRst, parLoadN, serClk, serData, serLoad, nPins, mPins};

  synth_cfg_sync #(.WIDTH(RAW_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rawIn(rawVec), .syncOut(syncVec), .prevOut(prevVec)
  );

  synth_cfg_strobe u_strobe (
    .syncPl(syncVec[RAW_W-2]), .prevPl(prevVec[RAW_W-2]),
    .syncCk(syncVec[RAW_W-3]), .prevCk(prevVec[RAW_W-3]),
    .syncLd(syncVec[RAW_W-5]), .prevLd(prevVec[RAW_W-5]),
    .strobe(strobe)
  );

  assign mrSync      = syncVec[RAW_W-1];
  assign serDataSync = syncVec[RAW_W-4];

  synth_cfg_core #(.M_WIDTH(M_WIDTH), .N_WIDTH(N_WIDTH)) u_core (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .mrSync(mrSync),
    .serDataSync(serDataSync),
    .pinM(syncVec[M_WIDTH-1:0]), .pinN(syncVec[M_WIDTH+N_WIDTH-1:M_WIDTH]),
    .mReg(mDiv), .nReg(nCode), .tReg(testSel), .shiftQ(shiftQ),
    .mPulse(mPulse), .testOut(testOut), .fOut(fOut), .fOutN(fOutN)
  );
endmodule

// File: rtl/synth_div_cfg_chk.sv
module synth_div_cfg_chk
  import synth_cfg_pkg::*;
#(
  parameter int M_WIDTH = 9,
  parameter int N_WIDTH = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input cfgStrobe_t                 st,
  input logic                       mrS,
  input logic                       sdS,
  input logic [M_WIDTH+N_WIDTH+2:0] shiftQ,
  input logic [M_WIDTH-1:0]         mDiv,
  input logic [N_WIDTH-1:0]         nCode,
  input logic [1:0]                 testSel,
  input logic                       testOut,
  input logic                       fOut,
  input logic                       fOutN,
  input logic                       mPulse
);
  localparam int FRAME = M_WIDTH + N_WIDTH + 3;

  assert_par_test_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    st.parMode |-> !testOut);

  assert_shift_in_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st.serShift |=> shiftQ[0] == $past(sdS));

  assert_xfer_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    st.serXfer |=> (mDiv == $past(shiftQ[M_WIDTH-1:0])) &&
                   (testSel == $past(shiftQ[FRAME-1:FRAME-2])));

  // R3 and R5: without a strobe the settings hold
  assert_settings_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!st.parMode && !st.parLatch && !st.serXfer && !st.serPass) |=>
      ($stable(mDiv) && $stable(nCode) && $stable(testSel)));

  assert_master_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mrS |=> (!fOut && fOutN && !mPulse));
endmodule

bind synth_div_cfg synth_div_cfg_chk #(.M_WIDTH(M_WIDTH), .N_WIDTH(N_WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(strobe), .mrS(mrSync), .sdS(serDataSync),
  .shiftQ(shiftQ), .mDiv(mDiv), .nCode(nCode), .testSel(testSel),
  .testOut(testOut), .fOut(fOut), .fOutN(fOutN), .mPulse(mPulse)
);

// File: tb/test_synth_div_cfg.sv
`timescale 1ns/100ps
module test_synth_div_cfg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic masterRst = 0, parLoadN = 0, serClk = 0, serData = 0, serLoad = 0;
  logic [8:0] mPins = '0;
  logic [1:0] nPins = '0;
  logic [8:0] mDiv;
  logic [1:0] nCode, testSel;
  logic testOut, fOut, fOutN;

  always #2.5 clk = ~clk;

  synth_div_cfg i_synth_div_cfg (
    .clk(clk), .rst_n(rst_n), .masterRst(masterRst), .parLoadN(parLoadN),
    .mPins(mPins), .nPins(nPins), .serClk(serClk), .serData(serData),
    .serLoad(serLoad), .mDiv(mDiv), .nCode(nCode), .testSel(testSel),
    .testOut(testOut), .fOut(fOut), .fOutN(fOutN)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  string phase = "R1";

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [15:0] hist[$] = '{16'h0, 16'h0, 16'h0};
  int eM = 0, eN = 0, eT = 0, oc = 0, mc = 0, mp = 0;
  int eSh = 0;

  function automatic logic [15:0] rawNow();
    return {masterRst, parLoadN, serClk, serData, serLoad, nPins, mPins};
  endfunction

  task automatic loadFromFrame(int f);
    eT = (f >> 12) & 3;
    eN = (f >> 9) & 3;
    eM = f & 9'h1FF;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{16'h0, 16'h0, 16'h0};
      eM = 0; eN = 0; eT = 0; oc = 0; mc = 0; mp = 0; eSh = 0;
    end else begin
      logic [15:0] cur, prv;
      cur = hist[1];
      prv = hist[2];
      if (cur[15]) begin oc = 0; mc = 0; mp = 0; end
      else begin
        oc = (oc + 1) % 16;
        if (mc + 1 >= eM) begin mc = 0; mp = 1; end
        else begin mc = mc + 1; mp = 0; end
      end
      if (!cur[14] || (cur[14] && !prv[14])) begin
        eM = cur[8:0];
        eN = cur[10:9];
      end else begin
        bit ld, ck;
        ld = cur[11] && !prv[11];
        ck = cur[13] && !prv[13];
        if (ld) loadFromFrame(eSh);
        if (ck) begin
          eSh = ((eSh << 1) | cur[12]) & 14'h3FFF;
          if (cur[11] && !ld) loadFromFrame(eSh);
        end
      end
      hist.push_front(rawNow());
      void'(hist.pop_back());
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [15:0] cur;
      int expF, expT;
      cur  = hist[1];
      expF = (oc >> eN) & 1;
      if (!cur[14]) expT = 0;
      else case (eT)
        0: expT = 0;
        1: expT = cur[12];
        2: expT = mp;
        default: expT = expF;
      endcase
      chk({phase, " mDiv"}, mDiv, eM);
      chk({phase, " nCode"}, nCode, eN);
      chk({phase, " testSel"}, testSel, eT);
      chk({phase, " testOut"}, testOut, expT);
      chk({phase, " fOut"}, fOut, expF);
      chk({phase, " fOutN"}, fOutN, 1 - expF);
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendFrame(int t, int nul, int n, int m);
    logic [13:0] f;
    f = {t[1:0], nul[0], n[1:0], m[8:0]};
    for (int i = 13; i >= 0; i--) begin
      serData = f[i];
      step(3);
      serClk = 1;
      step(3);
      serClk = 0;
      step(3);
    end
  endtask

  task automatic pulseLoad();
    serLoad = 1; step(5);
    serLoad = 0; step(5);
  endtask

  initial begin
    int rises, highs;
    logic prevT;
    step(4);
    // R1 reset state
    chk("R1 mDiv", mDiv, 0);
    chk("R1 nCode", nCode, 0);
    chk("R1 testSel", testSel, 0);
    chk("R1 testOut", testOut, 0);
    chk("R1 fOut", fOut, 0);
    chk("R1 fOutN", fOutN, 1);
    rst_n = 1;
    step(4);

    // R2 parallel transparent
    phase = "R2";
    mPins = 9'h0A5; nPins = 2; step(6);
    chk("R2 mDiv pins", mDiv, 9'h0A5);
    chk("R2 nCode pins", nCode, 2);
    mPins = 9'h13C; nPins = 1; step(6);
    chk("R2 mDiv follows", mDiv, 9'h13C);
    chk("R2 testOut low", testOut, 0);

    // R3 latch on rising strobe
    phase = "R3";
    parLoadN = 1; step(6);
    mPins = 9'h1FF; nPins = 3; step(6);
    chk("R3 mDiv held", mDiv, 9'h13C);
    chk("R3 nCode held", nCode, 1);

    // R11 latency: third edge
    phase = "R11";
    parLoadN = 0; mPins = 9'h055; nPins = 0;
    step(1); chk("R11 edge1", mDiv, 9'h13C);
    step(1); chk("R11 edge2", mDiv, 9'h13C);
    step(1); chk("R11 edge3", mDiv, 9'h055);
    parLoadN = 1; step(6);

    // R4 shifting with null slot = 1 leaves outputs alone
    phase = "R4";
    sendFrame(1, 1, 3, 9'h1A5);
    chk("R4 shift only", mDiv, 9'h055);
    chk("R4 shift only T", testSel, 0);
    phase = "R5";
    pulseLoad();
    chk("R5 xfer mDiv", mDiv, 9'h1A5);
    chk("R5 xfer nCode", nCode, 3);
    chk("R4 null slot ignored testSel", testSel, 1);

    // R7 select 1: serial input
    phase = "R7";
    serData = 1; step(4);
    chk("R7 sel1 high", testOut, 1);
    serData = 0; step(4);
    chk("R7 sel1 low", testOut, 0);

    // R5 hold after falling load
    phase = "R5";
    sendFrame(2, 0, 0, 7);
    chk("R5 held after fall", mDiv, 9'h1A5);
    pulseLoad();
    chk("R5 second xfer", mDiv, 7);
    chk("R5 second sel", testSel, 2);

    // R10 divider pulse: 70 cycles with M=7 gives 10 pulses
    phase = "R10";
    highs = 0;
    for (int i = 0; i < 70; i++) begin step(1); highs += testOut; end
    chk("R10 pulse count M=7", highs, 10);

    // R8 output clock for each code
    phase = "R8";
    for (int n = 0; n < 4; n++) begin
      sendFrame(3, 0, n, 25);
      pulseLoad();
      rises = 0; highs = 0;
      step(1); prevT = testOut;
      for (int i = 0; i < 64; i++) begin
        step(1);
        if (testOut && !prevT) rises++;
        highs += testOut;
        prevT = testOut;
      end
      chk($sformatf("R8 rises code %0d", n), rises, 64 >> (n + 1));
      chk($sformatf("R8 duty code %0d", n), highs, 32);
    end

    // R6 pass-through while serLoad held high
    phase = "R6";
    serLoad = 1; step(5);
    sendFrame(3, 0, 1, 9'h0F0);
    chk("R6 pass mDiv", mDiv, 9'h0F0);
    chk("R6 pass nCode", nCode, 1);
    serLoad = 0; step(5);

    // R9 master reset
    phase = "R9";
    masterRst = 1; step(6);
    chk("R9 fOut low", fOut, 0);
    chk("R9 fOutN high", fOutN, 1);
    chk("R9 mDiv kept", mDiv, 9'h0F0);
    chk("R9 testSel kept", testSel, 3);
    masterRst = 0; step(6);

    // mode switch: serial -> parallel -> serial event
    phase = "R2";
    mPins = 9'h0C8; nPins = 2; parLoadN = 0; step(6);
    chk("R2 switch mDiv", mDiv, 9'h0C8);
    chk("R2 switch testOut", testOut, 0);
    parLoadN = 1; step(6);
    phase = "R3";
    pulseLoad();
    chk("R3 serial event overrides", mDiv, 9'h0F0);

    // R7 select 0
    phase = "R7";
    sendFrame(0, 1, 0, 9'h033);
    pulseLoad();
    highs = 0;
    for (int i = 0; i < 20; i++) begin step(1); highs += testOut; end
    chk("R7 sel0 low", highs, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired in phase %s actual=running expected=finished", phase);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule